// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the low column address for each data beat of a memory burst. A one-cycle start pulse carries a starting column address, a burst length select and an ordering select. From the next cycle on, the block presents one column address per cycle, with a valid flag and a flag on the final beat, until the burst has run its length. It is meant to sit between a memory command scheduler and the datapath that steps through the columns of an open row.

The burst length sets a window of low address bits: one bit for a two-beat burst, two bits for four beats and three bits for eight beats. Only the bits inside that window are stepped. Every bit above the window, including low bits that fall outside a short window, is copied from the starting address on every beat. Two orderings are available. The wrapping order adds the beat number to the start offset and wraps inside the window. The interleaved order XORs the start offset with the beat number.

Burst length and ordering are captured with the start pulse. A start pulse on the final beat chains a new burst with no idle cycle between them. A start pulse that carries an unsupported length code produces a one-cycle error flag and no beats.

Top module: `burst_col_seq`

## Requirements
- R1: A start pulse with a legal length code, taken while idle, makes the first beat valid on the next cycle, and that beat carries the starting address unchanged.
- R2: On every beat, all address bits outside the burst window equal the corresponding bits of the starting address.
- R3: With ordering select 0 (wrapping), the in-window part of beat i is (start offset + i) modulo the burst length.
- R4: With ordering select 1 (interleaved), the in-window part of beat i is the start offset XOR i.
- R5: For a two-beat burst both orderings give beats 0,1 from offset 0 and 1,0 from offset 1.
- R6: Length and ordering are taken from the start cycle only; changes to the select inputs and the address input during a burst do not alter its beats.
- R7: The last flag is high only on beat number (burst length - 1), always together with valid; when no start pulse arrives on that beat, valid is low on the next cycle.
- R8: A legal start pulse on the final beat makes the next cycle beat 0 of the new burst, with no idle cycle.
- R9: Length codes map as 1 = two beats, 2 = four beats, 3 = eight beats; codes 0 and 4 to 7 are reserved. A start pulse with a reserved code, taken while idle or on the final beat, raises the error flag for exactly the next cycle and produces no valid beat.
- R10: A start pulse on any beat other than the final one is ignored: the running burst continues unchanged and no error flag is raised.
- R11: While reset is held, valid, last and the error flag are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| start_i | input | 1 | One-cycle request to begin a burst |
| start_addr_i | input | COL_W | Starting column address |
| blen_sel_i | input | 3 | Burst length code (see R9) |
| btype_i | input | 1 | Ordering select: 0 wrapping, 1 interleaved |
| beat_valid_o | output | 1 | A beat address is presented this cycle |
| beat_last_o | output | 1 | This beat is the final beat of the burst |
| beat_addr_o | output | COL_W | Column address of the current beat |
| err_o | output | 1 | A start pulse with a reserved length code was rejected in the previous cycle |

## Verification
The hardest situation to reach from the ports is the final beat, where a start pulse must chain a new burst while a stray pulse one beat earlier must be ignored, all while the select inputs are being changed under a running burst. The stimulus drives a random, possibly reserved, start pulse on every non-final beat with random select and address values, and on the final beat either chains a second burst of random length and ordering or drops the request. Directed cases cover the two-beat orderings, the documented four- and eight-beat examples and a reserved code given both from idle and on a final beat.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  // Widest burst window: eight beats need three in-window bits.
  localparam int unsigned WIN_W   = 3;
  localparam int unsigned BLSEL_W = 3;

  localparam logic [BLSEL_W-1:0] BLSEL_TWO   = 3'd1;
  localparam logic [BLSEL_W-1:0] BLSEL_FOUR  = 3'd2;
  localparam logic [BLSEL_W-1:0] BLSEL_EIGHT = 3'd3;

  typedef enum logic {
    ORD_WRAP  = 1'b0,
    ORD_INTLV = 1'b1
  } order_e;

  // Captured burst configuration. The final beat index equals the window
  // mask, because the burst length is always a power of two.
  typedef struct packed {
    logic [WIN_W-1:0] mask;
    order_e           order;
  } burst_cfg_t;

  function automatic logic blsel_legal(input logic [BLSEL_W-1:0] code);
    return (code == BLSEL_TWO) || (code == BLSEL_FOUR) || (code == BLSEL_EIGHT);
  endfunction

endpackage

// File: rtl/bcs_rst_sync.sv
module bcs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sn = chain_q[STAGES-1];

endmodule

// File: rtl/bcs_cfg_decode.sv
module bcs_cfg_decode
  import bcs_pkg::*;
(
  input  logic [BLSEL_W-1:0] blen_sel_i,
  input  logic               btype_i,
  output logic               legal_o,
  output burst_cfg_t         cfg_o
);

  logic [WIN_W-1:0] mask;

  assign legal_o = blsel_legal(blen_sel_i);

  // Window bit b is stepped when the burst holds more than 2**b beats,
  // i.e. when the length code is above b.
  for (genvar b = 0; b < WIN_W; b++) begin : g_mask
    assign mask[b] = legal_o && (blen_sel_i > BLSEL_W'(b));
  end

  always_comb begin
    cfg_o.mask  = mask;
    cfg_o.order = btype_i ? ORD_INTLV : ORD_WRAP;
  end

endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             legal_i,
  input  burst_cfg_t       cfg_i,
  input  logic [COL_W-1:0] addr_i,
  output logic             busy_o,
  output logic             last_o,
  output logic [WIN_W-1:0] cnt_o,
  output burst_cfg_t       cfg_o,
  output logic [COL_W-1:0] base_o,
  output logic             err_o
);

  logic             busy_q, busy_d;
  logic             err_q,  err_d;
  logic [WIN_W-1:0] cnt_q,  cnt_d;
  burst_cfg_t       cfg_q;
  logic [COL_W-1:0] base_q;

  logic accept;
  logic load;
  logic reject;
  logic last;
  logic cnt_en;
  logic cfg_en;

  always_comb begin
    last   = busy_q && (cnt_q == cfg_q.mask);
    accept = start_i && (!busy_q || last);
    load   = accept && legal_i;
    reject = accept && !legal_i;

    cfg_en = load;
    cnt_en = load || (busy_q && !last);

    if (load) begin
      busy_d = 1'b1;
    end else if (last) begin
      busy_d = 1'b0;
    end else begin
      busy_d = busy_q;
    end

    cnt_d = load ? '0 : cnt_q + 1'b1;
    err_d = reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
      cfg_q  <= '0;
      base_q <= '0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      if (cfg_en) begin
        cfg_q  <= cfg_i;
        base_q <= addr_i;
      end
    end
  end

  assign busy_o = busy_q;
  assign last_o = last;
  assign cnt_o  = cnt_q;
  assign cfg_o  = cfg_q;
  assign base_o = base_q;
  assign err_o  = err_q;

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [WIN_W-1:0] cnt_i,
  input  burst_cfg_t       cfg_i,
  output logic [COL_W-1:0] addr_o
);

  localparam int unsigned UP_W = COL_W - WIN_W;

  logic [WIN_W-1:0] start_off;
  logic [WIN_W-1:0] step_off;

  assign start_off = base_i[WIN_W-1:0];

  always_comb begin
    if (cfg_i.order == ORD_INTLV) begin
      step_off = start_off ^ cnt_i;
    end else begin
      step_off = start_off + cnt_i;
    end
  end

  // Bits inside the window take the stepped offset, the rest keep the base.
  for (genvar b = 0; b < WIN_W; b++) begin : g_win
    assign addr_o[b] = cfg_i.mask[b] ? step_off[b] : base_i[b];
  end

  if (UP_W > 0) begin : g_upper
    assign addr_o[COL_W-1:WIN_W] = base_i[COL_W-1:WIN_W];
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [COL_W-1:0]   start_addr_i,
  input  logic [BLSEL_W-1:0] blen_sel_i,
  input  logic               btype_i,
  output logic               beat_valid_o,
  output logic               beat_last_o,
  output logic [COL_W-1:0]   beat_addr_o,
  output logic               err_o
);

  logic             rst_sn;
  logic             legal;
  burst_cfg_t       cfg_in;
  burst_cfg_t       cfg_run;
  logic [WIN_W-1:0] cnt;
  logic [COL_W-1:0] base;

  bcs_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  bcs_cfg_decode u_decode (
    .blen_sel_i (blen_sel_i),
    .btype_i    (btype_i),
    .legal_o    (legal),
    .cfg_o      (cfg_in)
  );

  bcs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sn),
    .start_i (start_i),
    .legal_i (legal),
    .cfg_i   (cfg_in),
    .addr_i  (start_addr_i),
    .busy_o  (beat_valid_o),
    .last_o  (beat_last_o),
    .cnt_o   (cnt),
    .cfg_o   (cfg_run),
    .base_o  (base),
    .err_o   (err_o)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_i (base),
    .cnt_i  (cnt),
    .cfg_i  (cfg_run),
    .addr_o (beat_addr_o)
  );

endmodule

// File: rtl/burst_col_seq_checker.sv
module burst_col_seq_checker
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input logic               clk,
  input logic               rst_sn,
  input logic               start_i,
  input logic [COL_W-1:0]   start_addr_i,
  input logic [BLSEL_W-1:0] blen_sel_i,
  input logic               beat_valid_o,
  input logic               beat_last_o,
  input logic [COL_W-1:0]   beat_addr_o,
  input logic               err_o
);

  logic open_slot;
  assign open_slot = !beat_valid_o || beat_last_o;

  AST_START_BEGINS: assert property (@(posedge clk) disable iff (!rst_sn)
    open_slot && start_i && blsel_legal(blen_sel_i)
      |=> beat_valid_o && (beat_addr_o == $past(start_addr_i)));  // R1

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_sn)
    beat_valid_o && !beat_last_o
      |=> beat_addr_o[COL_W-1:WIN_W] == $past(beat_addr_o[COL_W-1:WIN_W]));  // R2

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_sn)
    beat_last_o |-> beat_valid_o);  // R7

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_sn)
    beat_last_o && !start_i |=> !beat_valid_o);  // R7

  AST_CHAIN_NO_GAP: assert property (@(posedge clk) disable iff (!rst_sn)
    beat_last_o && start_i && blsel_legal(blen_sel_i) |=> beat_valid_o);  // R8

  AST_RSVD_REJECT: assert property (@(posedge clk) disable iff (!rst_sn)
    open_slot && start_i && !blsel_legal(blen_sel_i) |=> err_o && !beat_valid_o);  // R9

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_sn)
    err_o |=> !err_o || $past(start_i));  // R9

  AST_MID_IGNORED: assert property (@(posedge clk) disable iff (!rst_sn)
    beat_valid_o && !beat_last_o |=> beat_valid_o && !err_o);  // R10

  always_comb begin
    if (!rst_sn) begin
      AST_RESET_QUIET: assert (!beat_valid_o && !beat_last_o && !err_o);  // R11
    end
  end

endmodule

bind burst_col_seq burst_col_seq_checker #(.COL_W(COL_W)) u_checker (
  .clk          (clk),
  .rst_sn       (rst_sn),
  .start_i      (start_i),
  .start_addr_i (start_addr_i),
  .blen_sel_i   (blen_sel_i),
  .beat_valid_o (beat_valid_o),
  .beat_last_o  (beat_last_o),
  .beat_addr_o  (beat_addr_o),
  .err_o        (err_o)
);

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;

  localparam int unsigned COL_W = 10;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [COL_W-1:0] start_addr_i;
  logic [2:0]       blen_sel_i;
  logic             btype_i;
  logic             beat_valid_o;
  logic             beat_last_o;
  logic [COL_W-1:0] beat_addr_o;
  logic             err_o;

  int nvec;
  int nerr;
  bit done;

  burst_col_seq #(.COL_W(COL_W)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .blen_sel_i   (blen_sel_i),
    .btype_i      (btype_i),
    .beat_valid_o (beat_valid_o),
    .beat_last_o  (beat_last_o),
    .beat_addr_o  (beat_addr_o),
    .err_o        (err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] win_mask(input logic [2:0] sel);
    return 3'((4'd1 << sel) - 4'd1);
  endfunction

  function automatic logic [COL_W-1:0] exp_addr(input logic [COL_W-1:0] a,
                                                input logic [2:0] sel,
                                                input logic typ,
                                                input int i);
    logic [2:0] m;
    logic [2:0] off;
    logic [2:0] low;
    m   = win_mask(sel);
    off = a[2:0] & m;
    low = typ ? ((off ^ 3'(i)) & m) : ((off + 3'(i)) & m);
    return {a[COL_W-1:3], (a[2:0] & ~m) | low};
  endfunction

  function automatic logic [2:0] rand_legal();
    return 3'(1 + ($urandom % 3));
  endfunction

  function automatic logic [2:0] rand_rsvd();
    logic [2:0] v;
    v = 3'($urandom % 5);
    return (v == 3'd0) ? 3'd0 : 3'(v + 3'd3);
  endfunction

  task automatic drive_start(input logic [COL_W-1:0] a, input logic [2:0] sel, input logic typ);
    start_i      = 1'b1;
    start_addr_i = a;
    blen_sel_i   = sel;
    btype_i      = typ;
    @(negedge clk);
  endtask

  // Checks a burst from beat 0; called at the negedge after its start was sampled.
  task automatic check_burst(input logic [COL_W-1:0] a, input logic [2:0] sel, input logic typ,
                             input bit chain, input logic [COL_W-1:0] na,
                             input logic [2:0] nsel, input logic ntyp);
    int bl;
    string otag;
    bl   = 1 << sel;
    otag = typ ? "R4/R6" : "R3/R6";
    if (sel == 3'd1) otag = {otag, "/R5"};
    for (int i = 0; i < bl; i++) begin
      chk("R1 valid", 32'(beat_valid_o), 32'd1);
      chk(otag, 32'(beat_addr_o), 32'(exp_addr(a, sel, typ, i)));
      chk("R2 upper", 32'(beat_addr_o[COL_W-1:3]), 32'(a[COL_W-1:3]));
      chk("R7 last", 32'(beat_last_o), 32'(i == bl - 1));
      chk("R10 err", 32'(err_o), 32'd0);
      if (i == bl - 1) begin
        start_i      = chain;
        start_addr_i = na;
        blen_sel_i   = nsel;
        btype_i      = ntyp;
      end else begin
        start_i      = 1'($urandom);
        start_addr_i = COL_W'($urandom);
        blen_sel_i   = 3'($urandom);
        btype_i      = 1'($urandom);
      end
      @(negedge clk);
    end
    if (!chain) begin
      chk("R7 idle", 32'(beat_valid_o), 32'd0);
      chk("R7 no err", 32'(err_o), 32'd0);
    end
  endtask

  task automatic burst(input logic [COL_W-1:0] a, input logic [2:0] sel, input logic typ);
    drive_start(a, sel, typ);
    check_burst(a, sel, typ, 1'b0, '0, 3'd0, 1'b0);
  endtask

  task automatic rsvd_from_idle(input logic [2:0] sel);
    drive_start(COL_W'($urandom), sel, 1'($urandom));
    start_i = 1'b0;
    chk("R9 err set", 32'(err_o), 32'd1);
    chk("R9 no beat", 32'(beat_valid_o), 32'd0);
    @(negedge clk);
    chk("R9 err single", 32'(err_o), 32'd0);
    chk("R9 still idle", 32'(beat_valid_o), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [COL_W-1:0] a, na;
    logic [2:0]       s, ns;
    logic             t, nt;
    nvec = 0;
    nerr = 0;
    done = 1'b0;
    void'($urandom(32'd20240611));
    rst_n        = 1'b0;
    start_i      = 1'b0;
    start_addr_i = '0;
    blen_sel_i   = 3'd0;
    btype_i      = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 valid", 32'(beat_valid_o), 32'd0);
    chk("R11 last", 32'(beat_last_o), 32'd0);
    chk("R11 err", 32'(err_o), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5: two-beat bursts in both orderings.
    burst(10'h3F0, 3'd1, 1'b0);
    burst(10'h3F1, 3'd1, 1'b0);
    burst(10'h0A0, 3'd1, 1'b1);
    burst(10'h0A1, 3'd1, 1'b1);
    // R3 / R4 worked examples.
    burst(10'h152, 3'd2, 1'b0);
    burst(10'h205, 3'd3, 1'b1);
    burst(10'h1FF, 3'd3, 1'b0);
    burst(10'h000, 3'd2, 1'b1);
    // R9: reserved codes from idle.
    rsvd_from_idle(3'd0);
    rsvd_from_idle(3'd7);
    // R8: chained bursts.
    drive_start(10'h11E, 3'd2, 1'b0);
    check_burst(10'h11E, 3'd2, 1'b0, 1'b1, 10'h2D5, 3'd3, 1'b1);
    check_burst(10'h2D5, 3'd3, 1'b1, 1'b0, '0, 3'd0, 1'b0);
    // R9: reserved code on the final beat ends the burst with an error pulse.
    drive_start(10'h043, 3'd1, 1'b0);
    check_burst(10'h043, 3'd1, 1'b0, 1'b1, 10'h3FF, 3'd6, 1'b0);
    start_i = 1'b0;
    chk("R9 err after last", 32'(err_o), 32'd1);
    chk("R9 no beat after last", 32'(beat_valid_o), 32'd0);
    @(negedge clk);
    chk("R9 err cleared", 32'(err_o), 32'd0);

    for (int n = 0; n < 400; n++) begin
      a = COL_W'($urandom);
      t = 1'($urandom);
      if (($urandom % 8) == 0) begin
        rsvd_from_idle(rand_rsvd());
      end else begin
        s = rand_legal();
        drive_start(a, s, t);
        while (($urandom % 4) == 0) begin
          na = COL_W'($urandom);
          ns = rand_legal();
          nt = 1'($urandom);
          check_burst(a, s, t, 1'b1, na, ns, nt);
          a = na;
          s = ns;
          t = nt;
        end
        check_burst(a, s, t, 1'b0, '0, 3'd0, 1'b0);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule